// File: doc/BRIEF.md
# Break Input Sampling Glitch Filter

This block sits on each filtered break path of a PWM power stage (the primary shutdown path and the secondary disable path), between the polarity-corrected break level and the shutdown logic. Its job is to keep switching noise and other short spurious pulses from tripping a shutdown. A real fault, one that stays active for longer than a programmed window, still gets through. The always-active-high system fault path does not pass through this block. Merging several fault sources and gating the outputs are handled elsewhere.

Each path has its own 4-bit filter setting. The setting picks a sampling divider applied to the dead-time reference tick and a number of consecutive active samples. The product of the two is the rejection window, counted in reference ticks. Setting 0 turns filtering off. A new setting is accepted only while that path's break function is disabled and the lock level is zero. This protects the setting against runaway software.

Top module: `brk_glitch_filter`

## Requirements
- R1: After a synchronous reset every filtered output is low and every path's setting is 0, which means unfiltered.
- R2: With setting 0 a path's output equals its break input as sampled at the previous clock edge.
- R3: A nonzero setting selects divider D and count N as follows: 1:(1,2) 2:(1,4) 3:(1,8) 4:(2,6) 5:(2,8) 6:(4,6) 7:(4,8) 8:(8,6) 9:(8,8) 10:(16,5) 11:(16,6) 12:(16,8) 13:(32,5) 14:(32,6) 15:(32,8). The window W is D*N ticks. With the input held active, the output rises at the edge of the (W+1)-th reference tick.
- R4: A pulse that stays active for W ticks or fewer never raises the output.
- R5: Any clock cycle with the input inactive clears the output and the sample count at the next edge. A new active run starts counting from zero.
- R6: Only clock cycles with the reference tick enable high advance the filter. Cycles with the enable low leave the count and the output unchanged.
- R7: A setting write is accepted only when that path's break enable is low and the lock level is 0. Any other write leaves the old setting in force. An accepted write restarts that path's filter with its output low.
- R8: Each path keeps its own setting and filter state. A write or a pulse on one path does not change the behaviour of another path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Dead-time reference tick enable |
| brk_in | input | PATHS | Polarity-corrected break level per path, active high |
| brk_en | input | PATHS | Break function enable per path, blocks setting writes |
| lock_lvl | input | 2 | Configuration lock level, nonzero freezes settings |
| cfg_wr | input | PATHS | Setting write strobe per path |
| cfg_code | input | 4 | Setting value written on a strobe |
| brk_filt | output | PATHS | Filtered break level per path |

## Verification
The main filtering function is driven with single active pulses whose lengths sit exactly at W and at W+1 ticks for the shortest, a middle and the longest settings. The W-tick pulse must be rejected and the W+1-tick pulse must produce a rising edge on exactly the predicted tick, which separates an off-by-one window from a correct one. A pulse split by a single inactive cycle tells a count that restarts apart from one that merely pauses. Holding the tick enable low on alternate cycles tells tick counting apart from clock counting. Writes attempted under an enabled break or a nonzero lock, and writes aimed at the other path, show through the output timing whether the old setting survived.

// File: rtl/brkf_pkg.sv
package brkf_pkg;
  localparam int CODE_W   = 4;
  localparam int MAX_DIV  = 32;
  localparam int MAX_CNT  = 8;
  localparam int DLOG_W   = $clog2($clog2(MAX_DIV) + 1);
  localparam int PC_W     = $clog2(MAX_DIV);
  localparam int CNT_W    = $clog2(MAX_CNT + 1);
  localparam int WIN_MAX  = MAX_DIV * MAX_CNT;
  localparam int RUN_W    = $clog2(WIN_MAX + 2);

  typedef struct packed {
    logic [DLOG_W-1:0] dlog;
    logic [CNT_W-1:0]  lim;
  } flt_sel_t;

  function automatic flt_sel_t sel_of(input logic [CODE_W-1:0] code);
    flt_sel_t s;
    case (code)
      4'd1:    s = '{dlog: 3'd0, lim: 4'd2};
      4'd2:    s = '{dlog: 3'd0, lim: 4'd4};
      4'd3:    s = '{dlog: 3'd0, lim: 4'd8};
      4'd4:    s = '{dlog: 3'd1, lim: 4'd6};
      4'd5:    s = '{dlog: 3'd1, lim: 4'd8};
      4'd6:    s = '{dlog: 3'd2, lim: 4'd6};
      4'd7:    s = '{dlog: 3'd2, lim: 4'd8};
      4'd8:    s = '{dlog: 3'd3, lim: 4'd6};
      4'd9:    s = '{dlog: 3'd3, lim: 4'd8};
      4'd10:   s = '{dlog: 3'd4, lim: 4'd5};
      4'd11:   s = '{dlog: 3'd4, lim: 4'd6};
      4'd12:   s = '{dlog: 3'd4, lim: 4'd8};
      4'd13:   s = '{dlog: 3'd5, lim: 4'd5};
      4'd14:   s = '{dlog: 3'd5, lim: 4'd6};
      4'd15:   s = '{dlog: 3'd5, lim: 4'd8};
      default: s = '{dlog: 3'd0, lim: 4'd0};
    endcase
    return s;
  endfunction
endpackage

// File: rtl/brkf_cfg.sv
module brkf_cfg
  import brkf_pkg::*;
#(
  parameter int LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              en_i,
  input  logic [LOCK_W-1:0] lock_i,
  output logic [CODE_W-1:0] code_o,
  output logic              restart_o
);
  logic [CODE_W-1:0] code_q;
  logic              take;

  assign take      = wr_i && !en_i && (lock_i == '0);
  assign restart_o = take;
  assign code_o    = code_q;

  always_ff @(posedge clk) begin
    if (rst)       code_q <= '0;
    else if (take) code_q <= code_i;
  end

  // R7
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && (en_i || lock_i != '0)) |=> $stable(code_q));
endmodule

// File: rtl/brkf_decode.sv
module brkf_decode
  import brkf_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic              bypass_o,
  output logic [PC_W-1:0]   div_m1_o,
  output logic [CNT_W-1:0]  lim_o,
  output logic [RUN_W-1:0]  win_o
);
  flt_sel_t sel;
  logic [PC_W:0] div_full;

  always_comb begin
    sel      = sel_of(code_i);
    div_full = (PC_W+1)'(1) << sel.dlog;
    bypass_o = (code_i == '0);
    div_m1_o = PC_W'(div_full - 1'b1);
    lim_o    = sel.lim;
    win_o    = RUN_W'(div_full) * RUN_W'(sel.lim);
  end
endmodule

// File: rtl/brkf_chan.sv
module brkf_chan
  import brkf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              brk_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              filt_o
);
  logic             bypass;
  logic [PC_W-1:0]  div_m1;
  logic [CNT_W-1:0] lim;
  logic [RUN_W-1:0] win;
  logic [PC_W-1:0]  pc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             filt_q;

  brkf_decode u_dec (
    .code_i  (code_i),
    .bypass_o(bypass),
    .div_m1_o(div_m1),
    .lim_o   (lim),
    .win_o   (win)
  );

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      pc_q   <= '0;
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (bypass) begin
      pc_q   <= '0;
      cnt_q  <= '0;
      filt_q <= brk_i;
    end else if (!brk_i) begin
      pc_q   <= '0;
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (tick_en) begin
      if (cnt_q == lim) begin
        filt_q <= 1'b1;
      end else if (pc_q == div_m1) begin
        pc_q  <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  // Checker: length of the current active run in ticks, saturating.
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || restart_i || bypass || !brk_i) run_q <= '0;
    else if (tick_en && run_q != '1)         run_q <= run_q + 1'b1;
  end

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bypass && !restart_i) |=> (filt_q == $past(brk_i)));
  // R5
  idle_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !brk_i |=> !filt_q);
  // R6
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && brk_i && !bypass && !restart_i) |=> $stable(filt_q));
  // R3
  window_exact_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(filt_q) && !bypass) |-> (run_q == win + 1'b1));
endmodule

// File: rtl/brk_glitch_filter.sv
module brk_glitch_filter
  import brkf_pkg::*;
#(
  parameter int PATHS  = 2,
  parameter int LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [PATHS-1:0]  brk_in,
  input  logic [PATHS-1:0]  brk_en,
  input  logic [LOCK_W-1:0] lock_lvl,
  input  logic [PATHS-1:0]  cfg_wr,
  input  logic [CODE_W-1:0] cfg_code,
  output logic [PATHS-1:0]  brk_filt
);
  for (genvar p = 0; p < PATHS; p++) begin : g_path
    logic [CODE_W-1:0] code;
    logic              restart;

    brkf_cfg #(.LOCK_W(LOCK_W)) u_cfg (
      .clk      (clk),
      .rst      (rst),
      .wr_i     (cfg_wr[p]),
      .code_i   (cfg_code),
      .en_i     (brk_en[p]),
      .lock_i   (lock_lvl),
      .code_o   (code),
      .restart_o(restart)
    );

    brkf_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .tick_en  (tick_en),
      .brk_i    (brk_in[p]),
      .restart_i(restart),
      .code_i   (code),
      .filt_o   (brk_filt[p])
    );
  end

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> (brk_filt == '0));
endmodule

// File: tb/test_brk_glitch_filter.sv
module test_brk_glitch_filter;
  localparam int CLK_PER = 10;
  localparam int NV = 11;
  localparam logic [3:0] V_CODE [NV] = '{4'd1, 4'd1, 4'd3, 4'd3, 4'd5, 4'd10,
                                         4'd13, 4'd15, 4'd15, 4'd0, 4'd8};
  localparam int V_LEN [NV] = '{2, 3, 8, 9, 17, 80, 161, 256, 257, 1, 49};

  logic       clk = 0;
  logic       rst = 1;
  logic       tick_en = 1;
  logic [1:0] brk_in = 0, brk_en = 0, cfg_wr = 0;
  logic [1:0] lock_lvl = 0;
  logic [3:0] cfg_code = 0;
  logic [1:0] brk_filt;
  int total = 0, bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  brk_glitch_filter i_brk_glitch_filter (
    .clk(clk), .rst(rst), .tick_en(tick_en), .brk_in(brk_in), .brk_en(brk_en),
    .lock_lvl(lock_lvl), .cfg_wr(cfg_wr), .cfg_code(cfg_code), .brk_filt(brk_filt)
  );

  function automatic int window(input logic [3:0] c);
    int d, n;
    case (c)
      1: begin d = 1;  n = 2; end   2: begin d = 1;  n = 4; end
      3: begin d = 1;  n = 8; end   4: begin d = 2;  n = 6; end
      5: begin d = 2;  n = 8; end   6: begin d = 4;  n = 6; end
      7: begin d = 4;  n = 8; end   8: begin d = 8;  n = 6; end
      9: begin d = 8;  n = 8; end   10: begin d = 16; n = 5; end
      11: begin d = 16; n = 6; end  12: begin d = 16; n = 8; end
      13: begin d = 32; n = 5; end  14: begin d = 32; n = 6; end
      15: begin d = 32; n = 8; end
      default: begin d = 0; n = 0; end
    endcase
    return d * n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_code(input int p, input logic [3:0] c);
    cfg_code = c; cfg_wr[p] = 1'b1;
    step();
    cfg_wr = '0;
  endtask

  // Holds path p active for len edges, returns the edge index of first rise (0 = none).
  task automatic pulse(input int p, input int len, output int first);
    first = 0;
    brk_in[p] = 1'b1;
    for (int k = 1; k <= len; k++) begin
      step();
      if (first == 0 && brk_filt[p]) first = k;
    end
    brk_in[p] = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first, exp;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: outputs low after reset
    chk(brk_filt == 2'b00, "R1 reset outputs", brk_filt, 0);
    // R1 R2: setting is 0 after reset, so input passes after one edge
    brk_in[1] = 1'b1;
    step();
    chk(brk_filt[1] == 1'b1, "R1 R2 reset bypass", brk_filt[1], 1);
    brk_in[1] = 1'b0;
    step();
    // R5: inactive input clears output
    chk(brk_filt[1] == 1'b0, "R5 bypass release", brk_filt[1], 0);

    // R3 R4 R2: vector table
    for (int v = 0; v < NV; v++) begin
      wr_code(0, V_CODE[v]);
      pulse(0, V_LEN[v], first);
      exp = (V_LEN[v] > window(V_CODE[v])) ? window(V_CODE[v]) + 1 : 0;
      chk(first == exp, $sformatf("R3 R4 code %0d len %0d", V_CODE[v], V_LEN[v]), first, exp);
      chk(brk_filt[0] == 1'b0, "R5 release after pulse", brk_filt[0], 0);
    end

    // R5: one inactive cycle restarts the count
    wr_code(0, 4'd1);
    first = 0;
    brk_in[0] = 1; step(); if (brk_filt[0]) first = 1; step(); if (brk_filt[0]) first = 1;
    brk_in[0] = 0; step();
    brk_in[0] = 1; step(); if (brk_filt[0]) first = 1; step(); if (brk_filt[0]) first = 1;
    chk(first == 0, "R5 gap restarts count", first, 0);
    step();
    chk(brk_filt[0] == 1'b1, "R5 third active tick of new run", brk_filt[0], 1);
    brk_in[0] = 0; step();
    chk(brk_filt[0] == 1'b0, "R5 immediate release", brk_filt[0], 0);

    // R6: tick enable high only on alternate cycles, code 1 needs 3 ticks
    brk_in[0] = 1; tick_en = 1;
    for (int e = 1; e <= 5; e++) begin
      step();
      tick_en = ~tick_en;
      if (e == 4) chk(brk_filt[0] == 1'b0, "R6 two ticks only", brk_filt[0], 0);
      if (e == 5) chk(brk_filt[0] == 1'b1, "R6 third tick", brk_filt[0], 1);
    end
    tick_en = 1; brk_in[0] = 0; step();

    // R7: write blocked by lock
    lock_lvl = 2'd1;
    wr_code(0, 4'd15);
    lock_lvl = 2'd0;
    pulse(0, 3, first);
    chk(first == 3, "R7 lock blocks write", first, 3);
    // R7: write blocked by enabled break
    brk_en[0] = 1;
    wr_code(0, 4'd15);
    brk_en[0] = 0;
    pulse(0, 3, first);
    chk(first == 3, "R7 enable blocks write", first, 3);
    // R7: accepted write takes effect
    wr_code(0, 4'd15);
    pulse(0, 3, first);
    chk(first == 0, "R7 accepted write", first, 0);
    // R7: accepted write restarts a path that is asserted
    wr_code(0, 4'd1);
    brk_in[0] = 1; step(); step(); step();
    cfg_code = 4'd1; cfg_wr[0] = 1; step(); cfg_wr = 0;
    chk(brk_filt[0] == 1'b0, "R7 write restarts filter", brk_filt[0], 0);
    brk_in[0] = 0; step();

    // R8: paths independent
    wr_code(1, 4'd15);
    brk_in = 2'b11;
    step(); step(); step();
    chk(brk_filt[0] == 1'b1, "R8 path0 code1", brk_filt[0], 1);
    chk(brk_filt[1] == 1'b0, "R8 path1 code15", brk_filt[1], 0);
    brk_in = 2'b00; step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule